// File: doc/BRIEF.md
# ADC Interrupt Flag and Enable Registers

This block keeps the interrupt state of an analog-to-digital converter controller. Six single-cycle event pulses from the converter logic each latch a sticky status flag. The events are: converter ready, end of sampling, end of conversion, end of sequence, overrun, and analog watchdog. Software sees the flags in a status register. It clears a flag by writing a one to its bit.

A second register holds one enable bit per flag. A single interrupt request line is raised whenever any flag is set while its enable is on. Three of the enables are locked while a conversion is running: end of sequence, overrun and watchdog. Writes to those bits are then dropped silently, and the other enable bits in the same write still update.

Access is through a simple 32-bit register bus with a select, a write strobe, a byte address and combinational read data.

Top module: `adc_irq_regs`

## Requirements
- R1: After reset, the status register, the enable register and `irqOut` are all zero.
- R2: The enable register sits at offset 0x04. Bits 0 to 4 and bit 7 are read/write. Bits 5, 6 and 31:8 always read zero.
- R3: The status register sits at offset 0x00. A one-cycle pulse on `hwEvt[i]` sets the flag for that source. The source order in `hwEvt` and the status/enable bit positions are: index 0 ready (bit 0), 1 end of sampling (bit 1), 2 end of conversion (bit 2), 3 end of sequence (bit 3), 4 overrun (bit 4), 5 watchdog (bit 7).
- R4: Writing 1 to a status bit clears that flag. Writing 0 leaves it unchanged. No write to the status register can set a flag.
- R5: If a hardware set pulse and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R6: While `convActive` is 1, writes do not change enable bits 3, 4 and 7. Bits 0, 1 and 2 in the same write still take the written value.
- R7: `irqOut` is registered. It equals the OR over all sources of (flag AND enable), taken one clock earlier.
- R8: A read at any offset other than 0x00 or 0x04 returns zero. A write there changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (8) | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of a read |
| convActive | input | 1 | A conversion is running; locks the protected enables |
| hwEvt | input | 6 | One-cycle set pulses, one per interrupt source |
| irqOut | output | 1 | Combined interrupt request |

## Verification
Read data is combinational, so a read is checked in the same cycle, before the next rising edge. It reflects every flag and enable update from earlier edges. A set pulse, a clear or an enable write is applied at one rising edge and becomes visible at the next read. `irqOut` trails the flag and enable state by exactly one more edge. The bench drives inputs at the falling edge and checks reads shortly after. Its model updates on each rising edge, and `irqOut` is compared 1 ns after that edge against the model state from before the edge.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;

  localparam int REG_W   = 32;
  localparam int NUM_SRC = 6;

  // Strobes handed from the bus decoder to the register datapath.
  typedef struct packed {
    logic wrStat;
    logic wrEn;
    logic rdStat;
    logic rdEn;
    logic enLock;
  } irqStrb_t;

  // Register bit position of each interrupt source.
  function automatic int srcPos(input int idx);
    int pos;
    if (idx < 5) pos = idx;
    else         pos = 7;
    return pos;
  endfunction

  function automatic logic [REG_W-1:0] validMaskFn();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) m[srcPos(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] VALID_MASK = validMaskFn();

  // Source indices whose enable is locked during a conversion.
  localparam logic [NUM_SRC-1:0] PROT_SRC = 6'b111000;

endpackage

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl
  import adc_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int STAT_OFF = 0,
  parameter int EN_OFF   = 4
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              convActive,
  output irqStrb_t          strb
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFF);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFF);

  logic hitStat;
  logic hitEn;

  assign hitStat = busSel && (busAddr == STAT_A);
  assign hitEn   = busSel && (busAddr == EN_A);

  always_comb begin
    strb        = '0;
    strb.wrStat = hitStat && busWrite;
    strb.rdStat = hitStat && !busWrite;
    strb.wrEn   = hitEn && busWrite;
    strb.rdEn   = hitEn && !busWrite;
    strb.enLock = convActive;
  end

endmodule

// File: rtl/adc_irq_datapath.sv
module adc_irq_datapath
  import adc_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  irqStrb_t           strb,
  input  logic [REG_W-1:0]   wdata,
  input  logic [NUM_SRC-1:0] hwEvt,
  output logic [REG_W-1:0]   rdata,
  output logic               irq
);

  logic [NUM_SRC-1:0] flagQ, flagD;
  logic [NUM_SRC-1:0] enQ, enD;
  logic [NUM_SRC-1:0] clrMask;
  logic [NUM_SRC-1:0] enWrMask;
  logic [NUM_SRC-1:0] wrBits;
  logic [REG_W-1:0]   statView;
  logic [REG_W-1:0]   enView;
  logic               irqQ;
  logic               unusedWdata;

  assign unusedWdata = ^(wdata & ~VALID_MASK);

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    localparam int P = srcPos(i);
    assign wrBits[i]   = wdata[P];
    assign clrMask[i]  = strb.wrStat & wdata[P];
    assign enWrMask[i] = strb.wrEn & ~(PROT_SRC[i] & strb.enLock);
    assign flagD[i]    = hwEvt[i] | (flagQ[i] & ~clrMask[i]);
    assign enD[i]      = enWrMask[i] ? wrBits[i] : enQ[i];
  end

  always_comb begin
    statView = '0;
    enView   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      statView[srcPos(i)] = flagQ[i];
      enView[srcPos(i)]   = enQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
      irqQ  <= 1'b0;
    end else begin
      flagQ <= flagD;
      enQ   <= enD;
      irqQ  <= |(flagQ & enQ);
    end
  end

  always_comb begin
    if (strb.rdStat)     rdata = statView;
    else if (strb.rdEn)  rdata = enView;
    else                 rdata = '0;
  end

  assign irq = irqQ;

  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((~flagQ & $past(flagQ) & ~$past(clrMask)) == '0));

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|hwEvt) |=> ((flagQ & $past(hwEvt)) == $past(hwEvt)));

  // R6
  en_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.enLock) |-> ((enQ & PROT_SRC) == ($past(enQ) & PROT_SRC)));

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> ($past(flagQ) != '0) && ($past(enQ) != '0));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rdata & ~VALID_MASK) == '0));

endmodule

// File: rtl/adc_irq_regs.sv
module adc_irq_regs
  import adc_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int STAT_OFF = 0,
  parameter int EN_OFF   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [REG_W-1:0]   busWdata,
  output logic [REG_W-1:0]   busRdata,
  input  logic               convActive,
  input  logic [NUM_SRC-1:0] hwEvt,
  output logic               irqOut
);

  irqStrb_t strb;

  adc_irq_ctrl #(
    .ADDR_W  (ADDR_W),
    .STAT_OFF(STAT_OFF),
    .EN_OFF  (EN_OFF)
  ) u_ctrl (
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .convActive(convActive),
    .strb      (strb)
  );

  adc_irq_datapath u_dp (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .wdata(busWdata),
    .hwEvt(hwEvt),
    .rdata(busRdata),
    .irq  (irqOut)
  );

endmodule

// File: tb/adc_irq_regs_tb.sv
module adc_irq_regs_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        convActive = 1'b0;
  logic [5:0]  hwEvt = '0;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [5:0] mFlag = '0;
  logic [5:0] mEn = '0;
  logic       mIrq = 1'b0;

  always #10 clk = ~clk;

  adc_irq_regs u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .convActive(convActive), .hwEvt(hwEvt), .irqOut(irqOut)
  );

  function automatic int posOf(input int i);
    return (i < 5) ? i : 7;
  endfunction

  function automatic logic [31:0] view(input logic [5:0] v);
    logic [31:0] r = '0;
    for (int i = 0; i < 6; i++) r[posOf(i)] = v[i];
    return r;
  endfunction

  function automatic logic [5:0] pick(input logic [31:0] d);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = d[posOf(i)];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at falling edge, check reads before the rising edge,
  // update the model at the rising edge and check irqOut just after it.
  task automatic step(input bit sel, input bit wr, input logic [7:0] addr,
                      input logic [31:0] wd, input bit conv, input logic [5:0] evt,
                      input string req);
    logic [31:0] expRd;
    logic [5:0]  nf, ne, clr;
    @(negedge clk);
    busSel = sel; busWrite = wr; busAddr = addr; busWdata = wd;
    convActive = conv; hwEvt = evt;
    #2;
    if (sel && !wr) begin
      if (addr == 8'h00)      expRd = view(mFlag);
      else if (addr == 8'h04) expRd = view(mEn);
      else                    expRd = '0;
      check(req, busRdata, expRd);
    end
    clr = (sel && wr && addr == 8'h00) ? pick(wd) : 6'b0;
    nf  = evt | (mFlag & ~clr);
    ne  = mEn;
    if (sel && wr && addr == 8'h04)
      for (int i = 0; i < 6; i++)
        if (!(conv && i >= 3)) ne[i] = wd[posOf(i)];
    @(posedge clk);
    mIrq  = |(mFlag & mEn);
    mFlag = nf;
    mEn   = ne;
    #1;
    check("R7", {31'b0, irqOut}, {31'b0, mIrq});
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    step(1, 0, a, 32'h0, 0, 6'b0, req);
  endtask

  task automatic idle();
    step(0, 0, 8'h0, 32'h0, 0, 6'b0, "R7");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", {31'b0, irqOut}, 32'h0);
    @(negedge clk) rstN = 1'b1;

    // R1 reset values
    rd(8'h00, "R1");
    rd(8'h04, "R1");
    check("R1", busRdata, 32'h0);

    // R2 writable enables and reserved bits
    step(1, 1, 8'h04, 32'hFFFF_FFFF, 0, 6'b0, "R2");
    rd(8'h04, "R2");
    check("R2", busRdata, 32'h0000_009F);
    step(1, 1, 8'h04, 32'h0, 0, 6'b0, "R2");

    // R3 each event sets its flag
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 8'h0, 32'h0, 0, 6'(1 << i), "R3");
      rd(8'h00, "R3");
      check("R3", busRdata, 32'(1) << posOf(i));
      step(1, 1, 8'h00, 32'(1) << posOf(i), 0, 6'b0, "R4");
    end

    // R4 write 0 keeps, write 1 clears, writes never set
    step(0, 0, 8'h0, 32'h0, 0, 6'b100001, "R4");
    step(1, 1, 8'h00, 32'h0, 0, 6'b0, "R4");
    rd(8'h00, "R4");
    check("R4", busRdata, 32'h0000_0081);
    step(1, 1, 8'h00, 32'h0000_0001, 0, 6'b0, "R4");
    rd(8'h00, "R4");
    check("R4", busRdata, 32'h0000_0080);
    step(1, 1, 8'h00, 32'hFFFF_FFFF, 0, 6'b0, "R4");
    step(1, 1, 8'h00, 32'hFFFF_FFFF, 0, 6'b0, "R4");
    rd(8'h00, "R4");
    check("R4", busRdata, 32'h0);

    // R5 set wins over simultaneous clear
    step(0, 0, 8'h0, 32'h0, 0, 6'b000100, "R5");
    step(1, 1, 8'h00, 32'h0000_0004, 0, 6'b000100, "R5");
    rd(8'h00, "R5");
    check("R5", busRdata, 32'h0000_0004);
    step(1, 1, 8'h00, 32'h0000_0004, 0, 6'b0, "R5");

    // R6 protected enables locked during conversion
    step(1, 1, 8'h04, 32'h0000_0098, 0, 6'b0, "R6");
    step(1, 1, 8'h04, 32'h0000_0007, 1, 6'b0, "R6");
    rd(8'h04, "R6");
    check("R6", busRdata, 32'h0000_009F);
    step(1, 1, 8'h04, 32'h0, 1, 6'b0, "R6");
    rd(8'h04, "R6");
    check("R6", busRdata, 32'h0000_0098);
    step(1, 1, 8'h04, 32'h0, 0, 6'b0, "R6");
    rd(8'h04, "R6");
    check("R6", busRdata, 32'h0);

    // R7 every flag/enable pair, matched and mismatched
    for (int i = 0; i < 6; i++) begin
      step(1, 1, 8'h04, 32'(1) << posOf(i), 0, 6'b0, "R7");
      step(0, 0, 8'h0, 32'h0, 0, 6'((1 << ((i + 1) % 6))), "R7");
      idle();
      check("R7", {31'b0, irqOut}, 32'h0);
      step(0, 0, 8'h0, 32'h0, 0, 6'(1 << i), "R7");
      idle();
      check("R7", {31'b0, irqOut}, 32'h1);
      step(1, 1, 8'h00, 32'hFFFF_FFFF, 0, 6'b0, "R4");
      idle();
      check("R7", {31'b0, irqOut}, 32'h0);
      step(1, 1, 8'h04, 32'h0, 0, 6'b0, "R7");
    end

    // R8 unmapped offsets
    step(0, 0, 8'h0, 32'h0, 0, 6'b111111, "R8");
    step(1, 1, 8'h08, 32'hFFFF_FFFF, 0, 6'b0, "R8");
    step(1, 1, 8'h05, 32'hFFFF_FFFF, 0, 6'b0, "R8");
    rd(8'h08, "R8");
    check("R8", busRdata, 32'h0);
    rd(8'h00, "R8");
    check("R8", busRdata, 32'h0000_009F);
    rd(8'h04, "R8");
    check("R8", busRdata, 32'h0);

    // Random mix checked against the model
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      int r = $urandom_range(0, 9);
      a = (r < 4) ? 8'h00 : (r < 8) ? 8'h04 : 8'($urandom_range(0, 255));
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a,
           $urandom(), $urandom_range(0, 2) == 0,
           6'($urandom()) & 6'($urandom()), "R3");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule